// File: doc/BRIEF.md
# Add/Subtract Unit with Processor Status Word

This block is the arithmetic slice of a small processor datapath. It adds or subtracts two operands, or passes the second operand straight through. Each operation can refresh six condition flags, which are kept in a registered 16-bit status word. The result is combinational, so it can be captured by a destination register in the same cycle. The flags take effect at the next rising clock edge, and only when the update enable is high. A byte mode treats the low eight bits as the whole operand: bit 7 then acts as the sign bit for sign, carry and overflow.

The same status word also holds three control flags: single-step, interrupt enable and string direction. Arithmetic operations never change them. They move only through per-flag set and clear strobes, which are sampled on the clock edge.

Top module: `psw_alu`

## Requirements
- R1: With `op_sel` = 2'b01 (add), `result` equals `op_a + op_b` modulo the operand width. Status bit 0 (carry) is set at the next edge exactly when the sum carries out of the operand MSB. Example: 2345H + 3219H gives 555EH with every condition flag 0.
- R2: With `op_sel` = 2'b10 (subtract), `result` equals `op_a - op_b` modulo the operand width. Status bit 0 is set exactly when the unsigned `op_b` exceeds `op_a` (a borrow into the MSB). Example: 1234H - 4AE0H gives C754H with sign and carry 1 and the other condition flags 0.
- R3: With `op_sel` = 2'b00 or 2'b11 (pass), `result` equals `op_b`. The carry (bit 0), half-carry (bit 4) and overflow (bit 11) flags are written as 0.
- R4: Bit 7 (sign) takes the result MSB. Bit 6 (zero) is 1 only for an all-zero result. Bit 2 (parity) is 1 when `result[7:0]` holds an even number of ones.
- R5: Bit 4 (half-carry) is set on a carry out of bit 3 for add, or on a borrow into bit 3 for subtract.
- R6: Bit 11 (overflow) is set when the carry into the MSB differs from the carry out of it. For subtract this is the equivalent borrow rule. Example: 5439H + 456AH gives 99A3H with sign, parity, half-carry and overflow set.
- R7: With `byte_mode` = 1, only `op_a[7:0]` and `op_b[7:0]` take part, `result[15:8]` is 0, and bit 7 is the MSB for the sign, carry and overflow flags.
- R8: Status bits 1, 3, 5 and 12 to 15 always read 0.
- R9: When `flag_upd` is 0, the condition flag bits (0, 2, 4, 6, 7, 11) keep their values through the edge.
- R10: Strobe index 0 drives status bit 8 (single-step), index 1 drives bit 9 (interrupt enable) and index 2 drives bit 10 (direction). A `ctl_set` bit sets its flag at the next edge and a `ctl_clr` bit clears it; when both are high, the clear wins. With no strobe, the flag holds its value through every operation.
- R11: While reset is asserted, and after it is released until the first update, `status` reads 0000H.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 16 | First operand (minuend for subtract) |
| op_b | input | 16 | Second operand (subtrahend, or the pass value) |
| op_sel | input | 2 | 00 pass, 01 add, 10 subtract, 11 pass |
| byte_mode | input | 1 | 1 selects 8-bit operation |
| flag_upd | input | 1 | 1 writes the condition flags at the next edge |
| ctl_set | input | 3 | Per-flag set strobes for the control flags |
| ctl_clr | input | 3 | Per-flag clear strobes, dominant over set |
| result | output | 16 | Combinational operation result |
| status | output | 16 | Registered processor status word |

## Verification
On every cycle, the assertions check the following:
- the unused status bits read 0;
- the upper result byte is 0 in byte mode;
- the condition flags and the control flags hold when nothing is allowed to write them;
- a clear strobe always wins;
- the zero and sign flags follow the result seen at the previous edge;
- pass operations leave carry, half-carry and overflow at 0.

The exact arithmetic of carry, borrow, half-carry and overflow, the low-byte parity, and the worked numeric examples are shown only by the bench's scenarios. Those scenarios are the directed edge cases plus a pseudo-random sweep compared against an independent model.

// File: rtl/psw_pkg.sv
package psw_pkg;

  localparam int PSW_W     = 16;
  localparam int NUM_CTL   = 3;

  localparam int POS_CARRY  = 0;
  localparam int POS_PARITY = 2;
  localparam int POS_HALF   = 4;
  localparam int POS_ZERO   = 6;
  localparam int POS_SIGN   = 7;
  localparam int POS_STEP   = 8;
  localparam int POS_INTEN  = 9;
  localparam int POS_DIR    = 10;
  localparam int POS_OVF    = 11;

  typedef enum logic [1:0] {
    OP_PASS  = 2'b00,
    OP_ADD   = 2'b01,
    OP_SUB   = 2'b10,
    OP_PASSX = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic sign;
    logic zero;
    logic half;
    logic parity;
    logic carry;
  } cond_t;

  function automatic logic [PSW_W-1:0] pack_status(input cond_t c,
                                                   input logic [NUM_CTL-1:0] k);
    logic [PSW_W-1:0] w;
    w             = '0;
    w[POS_CARRY]  = c.carry;
    w[POS_PARITY] = c.parity;
    w[POS_HALF]   = c.half;
    w[POS_ZERO]   = c.zero;
    w[POS_SIGN]   = c.sign;
    w[POS_OVF]    = c.ovf;
    w[POS_STEP]   = k[0];
    w[POS_INTEN]  = k[1];
    w[POS_DIR]    = k[2];
    return w;
  endfunction

endpackage

// File: rtl/psw_addsub.sv
module psw_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c_nib,
  output logic         c_lo_in,
  output logic         c_lo_out,
  output logic         c_hi_in,
  output logic         c_hi_out
);
  localparam int NIB_W = 4;
  localparam int LO_W  = 8;

  logic [W-1:0] b_eff;
  logic [W:0]   cy;

  assign b_eff = b ^ {W{sub}};
  assign cy[0] = sub;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p         = a[i] ^ b_eff[i];
    assign sum[i]    = p ^ cy[i];
    assign cy[i+1]   = (a[i] & b_eff[i]) | (cy[i] & p);
  end

  assign c_nib    = cy[NIB_W];
  assign c_lo_in  = cy[LO_W-1];
  assign c_lo_out = cy[LO_W];
  assign c_hi_in  = cy[W-1];
  assign c_hi_out = cy[W];

endmodule

// File: rtl/psw_flag_gen.sv
module psw_flag_gen
  import psw_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] sum,
  input  logic         byte_mode,
  input  logic         arith,
  input  logic         sub,
  input  logic         c_nib,
  input  logic         c_lo_in,
  input  logic         c_lo_out,
  input  logic         c_hi_in,
  input  logic         c_hi_out,
  output logic [W-1:0] res,
  output cond_t        cond
);
  localparam int LO_W = 8;

  logic msb, cin_msb, cout_msb;

  always_comb begin
    if (byte_mode) begin
      res      = {{(W-LO_W){1'b0}}, sum[LO_W-1:0]};
      msb      = sum[LO_W-1];
      cin_msb  = c_lo_in;
      cout_msb = c_lo_out;
    end else begin
      res      = sum;
      msb      = sum[W-1];
      cin_msb  = c_hi_in;
      cout_msb = c_hi_out;
    end
    cond.carry  = arith & (cout_msb ^ sub);
    cond.half   = arith & (c_nib ^ sub);
    cond.ovf    = arith & (cin_msb ^ cout_msb);
    cond.sign   = msb;
    cond.zero   = (res == '0);
    cond.parity = ~^res[LO_W-1:0];
  end

endmodule

// File: rtl/psw_ctl_reg.sv
module psw_ctl_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_int_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q
);
  logic [N-1:0] q_d;

  always_comb begin
    q_d = (q | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) q <= '0;
    else            q <= q_d;
  end

endmodule

// File: rtl/psw_alu.sv
module psw_alu
  import psw_pkg::*;
#(
  parameter int W = PSW_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0]        op_a,
  input  logic [W-1:0]        op_b,
  input  logic [1:0]          op_sel,
  input  logic                byte_mode,
  input  logic                flag_upd,
  input  logic [NUM_CTL-1:0]  ctl_set,
  input  logic [NUM_CTL-1:0]  ctl_clr,
  output logic [W-1:0]        result,
  output logic [PSW_W-1:0]    status
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_n, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_int_n  <= rst_meta_n;
    end
  end

  // operand steering
  alu_op_e      op;
  logic         arith, sub;
  logic [W-1:0] a_in;
  assign op    = alu_op_e'(op_sel);
  assign sub   = (op == OP_SUB);
  assign arith = (op == OP_ADD) || (op == OP_SUB);
  assign a_in  = arith ? op_a : '0;

  logic [W-1:0] sum;
  logic c_nib, c_lo_in, c_lo_out, c_hi_in, c_hi_out;

  psw_addsub #(.W(W)) i_addsub (
    .a(a_in), .b(op_b), .sub(sub), .sum(sum),
    .c_nib(c_nib), .c_lo_in(c_lo_in), .c_lo_out(c_lo_out),
    .c_hi_in(c_hi_in), .c_hi_out(c_hi_out)
  );

  cond_t cond_new;
  psw_flag_gen #(.W(W)) i_flags (
    .sum(sum), .byte_mode(byte_mode), .arith(arith), .sub(sub),
    .c_nib(c_nib), .c_lo_in(c_lo_in), .c_lo_out(c_lo_out),
    .c_hi_in(c_hi_in), .c_hi_out(c_hi_out),
    .res(result), .cond(cond_new)
  );

  // condition flag register
  cond_t cond_q, cond_d;
  always_comb begin
    cond_d = cond_q;
    if (flag_upd) cond_d = cond_new;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cond_q <= '0;
    else            cond_q <= cond_d;
  end

  // control flag register
  logic [NUM_CTL-1:0] ctl_q;
  psw_ctl_reg #(.N(NUM_CTL)) i_ctl (
    .clk(clk), .rst_int_n(rst_int_n),
    .set_i(ctl_set), .clr_i(ctl_clr), .q(ctl_q)
  );

  assign status = pack_status(cond_q, ctl_q);

endmodule

// File: rtl/psw_alu_chk.sv
module psw_alu_chk (
  input logic        clk,
  input logic        rst_int_n,
  input logic [1:0]  op_sel,
  input logic        byte_mode,
  input logic        flag_upd,
  input logic [2:0]  ctl_set,
  input logic [2:0]  ctl_clr,
  input logic [15:0] result,
  input logic [15:0] status
);
  localparam logic [15:0] UNUSED_MASK = 16'hF02A;
  localparam logic [15:0] COND_MASK   = 16'h08D5;

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status & UNUSED_MASK) == 16'h0); // R8

  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    byte_mode |-> result[15:8] == 8'h00); // R7

  AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !flag_upd |=> $stable(status & COND_MASK)); // R9

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ctl_set == 3'b0 && ctl_clr == 3'b0) |=> $stable(status[10:8])); // R10

  AST_CTL_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|ctl_clr) |=> (status[10:8] & $past(ctl_clr)) == 3'b0); // R10

  AST_ZERO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_upd |=> status[6] == ($past(result) == 16'h0)); // R4

  AST_SIGN_WORD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_upd && !byte_mode) |=> status[7] == $past(result[15])); // R4

  AST_PASS_CLEAR: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_upd && (op_sel == 2'b00 || op_sel == 2'b11)) |=>
      (status[0] == 1'b0 && status[4] == 1'b0 && status[11] == 1'b0)); // R3

endmodule

bind psw_alu psw_alu_chk i_chk (.*);

// File: tb/test_psw_alu.sv
module test_psw_alu;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] op_a, op_b;
  logic [1:0]  op_sel;
  logic        byte_mode, flag_upd;
  logic [2:0]  ctl_set, ctl_clr;
  logic [15:0] result, status;

  always #2 clk = ~clk;

  psw_alu i_psw_alu (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
    .byte_mode(byte_mode), .flag_upd(flag_upd), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .result(result), .status(status)
  );

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // expected state model
  logic e_cf, e_pf, e_af, e_zf, e_sf, e_of;
  logic [2:0] e_ctl;

  logic [15:0] q_res[$];
  logic [15:0] q_st[$];
  string       q_req[$];

  task automatic check16(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_status();
    return {4'b0, e_of, e_ctl[2], e_ctl[1], e_ctl[0], e_sf, e_zf,
            1'b0, e_af, 1'b0, e_pf, 1'b0, e_cf};
  endfunction

  task automatic drive(input logic [1:0] op, input logic [15:0] a,
                       input logic [15:0] b, input logic bm, input logic upd,
                       input logic [2:0] s, input logic [2:0] c,
                       input string req);
    logic [15:0] m, aa, bb, r;
    logic [16:0] wide;
    logic [4:0]  nib;
    logic cf, af, of;
    int msb;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op; byte_mode = bm; flag_upd = upd;
    ctl_set = s; ctl_clr = c;
    m   = bm ? 16'h00FF : 16'hFFFF;
    msb = bm ? 7 : 15;
    aa  = a & m;
    bb  = b & m;
    if (op == 2'b01) begin
      wide = {1'b0, aa} + {1'b0, bb};
      r    = wide[15:0] & m;
      cf   = bm ? wide[8] : wide[16];
      nib  = {1'b0, aa[3:0]} + {1'b0, bb[3:0]};
      af   = nib[4];
      of   = (aa[msb] == bb[msb]) && (r[msb] != aa[msb]);
    end else if (op == 2'b10) begin
      r  = (aa - bb) & m;
      cf = aa < bb;
      af = aa[3:0] < bb[3:0];
      of = (aa[msb] != bb[msb]) && (r[msb] != aa[msb]);
    end else begin
      r  = bb;
      cf = 1'b0; af = 1'b0; of = 1'b0;
    end
    if (upd) begin
      e_cf = cf; e_af = af; e_of = of;
      e_zf = (r == 16'h0);
      e_sf = r[msb];
      e_pf = ~^r[7:0];
    end
    e_ctl = (e_ctl | s) & ~c;
    q_res.push_back(r);
    q_st.push_back(exp_status());
    q_req.push_back(req);
    @(posedge clk);
    #1;
  endtask

  // monitor: compares what the driver predicted
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_res.size() > 0) begin
        logic [15:0] er, es;
        string rq;
        er = q_res.pop_front();
        es = q_st.pop_front();
        rq = q_req.pop_front();
        check16(rq, "result", result, er);
        check16(rq, "status", status, es);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    e_cf = 0; e_pf = 0; e_af = 0; e_zf = 0; e_sf = 0; e_of = 0; e_ctl = 3'b0;
    rst_n = 1'b0;
    op_a = 16'h1111; op_b = 16'h2222; op_sel = 2'b01; byte_mode = 1'b0;
    flag_upd = 1'b1; ctl_set = 3'b111; ctl_clr = 3'b000;
    repeat (3) @(posedge clk);
    #1 check16("R11", "status in reset", status, 16'h0000);
    @(negedge clk);
    flag_upd = 1'b0; ctl_set = 3'b000;
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1 check16("R11", "status after reset", status, 16'h0000);

    // worked examples
    drive(2'b01, 16'h2345, 16'h3219, 0, 1, 3'b0, 3'b0, "R1");
    check16("R1", "example sum", result, 16'h555E);
    check16("R1", "example flags", status, 16'h0000);
    drive(2'b01, 16'h5439, 16'h456A, 0, 1, 3'b0, 3'b0, "R6");
    check16("R6", "example sum", result, 16'h99A3);
    check16("R6", "example flags", status, 16'h0894);
    drive(2'b10, 16'h1234, 16'h4AE0, 0, 1, 3'b0, 3'b0, "R2");
    check16("R2", "example diff", result, 16'hC754);
    check16("R2", "example flags", status, 16'h0081);

    // word edge cases
    drive(2'b01, 16'hFFFF, 16'h0001, 0, 1, 3'b0, 3'b0, "R4 R5 zero with carry");
    check16("R4", "wrap flags", status, 16'h0055);
    drive(2'b10, 16'h8000, 16'h0001, 0, 1, 3'b0, 3'b0, "R6 sub overflow");
    drive(2'b10, 16'h0010, 16'h0001, 0, 1, 3'b0, 3'b0, "R5 nibble borrow");
    drive(2'b10, 16'h4321, 16'h4321, 0, 1, 3'b0, 3'b0, "R4 equal operands");

    // pass-through
    drive(2'b00, 16'hFFFF, 16'h0000, 0, 1, 3'b0, 3'b0, "R3 pass zero");
    drive(2'b11, 16'h1234, 16'h8F0F, 0, 1, 3'b0, 3'b0, "R3 pass alt code");

    // byte mode
    drive(2'b01, 16'hAB7F, 16'hCD01, 1, 1, 3'b0, 3'b0, "R7 byte overflow");
    check16("R7", "byte sum", result, 16'h0080);
    drive(2'b10, 16'h5500, 16'h0001, 1, 1, 3'b0, 3'b0, "R7 byte borrow");
    check16("R7", "byte borrow flags", status, 16'h0095);
    drive(2'b01, 16'h00FF, 16'h0001, 1, 1, 3'b0, 3'b0, "R7 byte carry");
    drive(2'b00, 16'hFFFF, 16'h1280, 1, 1, 3'b0, 3'b0, "R7 byte pass");

    // update enable low
    drive(2'b01, 16'h7FFF, 16'h0001, 0, 0, 3'b0, 3'b0, "R9 hold");
    drive(2'b10, 16'h0000, 16'h0001, 0, 0, 3'b0, 3'b0, "R9 hold");

    // control flags
    drive(2'b01, 16'h0001, 16'h0001, 0, 1, 3'b001, 3'b000, "R10 set step");
    drive(2'b01, 16'h0002, 16'h0003, 0, 1, 3'b110, 3'b000, "R10 set others");
    check16("R10", "all control set", status & 16'h0700, 16'h0700);
    drive(2'b10, 16'h0005, 16'h0007, 0, 1, 3'b000, 3'b000, "R10 hold over op");
    drive(2'b00, 16'h0000, 16'h0000, 0, 1, 3'b010, 3'b010, "R10 clear wins");
    check16("R10", "clear wins", status & 16'h0700, 16'h0500);
    drive(2'b00, 16'h0000, 16'h0000, 0, 0, 3'b000, 3'b101, "R10 clear");
    check16("R8", "unused bits", status & 16'hF02A, 16'h0000);

    // pseudo-random sweep
    lf = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      logic [15:0] a, b;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      a  = lf;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      b  = lf ^ 16'h5A5A;
      drive(lf[1:0], a, b, lf[4], lf[7] | lf[8], {1'b0, lf[9], 1'b0},
            {lf[11], 1'b0, lf[12]}, "R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 sweep");
    end

    @(negedge clk);
    flag_upd = 1'b0; ctl_set = 3'b0; ctl_clr = 3'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule